// File: doc/BRIEF.md
# Two-Road Intersection Light Sequencer

This block sequences the lamps of an intersection where two roads, A and B, meet. It keeps two registered state bits and derives all six lamp signals, a strobe that restarts an external interval timer, and its own next state from a fixed set of factored logic equations built on a few named intermediate terms. Three single-bit inputs come from outside: a sensor or timer flag for road A traffic, a second flag for road B traffic, and a "delay elapsed" flag from the interval timer.

A synchronous start input forces the block into its initial state at the next clock edge and silences every output for as long as it is held. All lamp and strobe outputs are combinational in the current state and the present inputs, so they react within the same cycle. The state bits are sampled on the rising clock edge. The external timer and the lamp drivers sit outside the block.

Top module: `tlc_top`

## Requirements
- R1: While rstN is low, both state bits (stateLo, stateHi) are held at 0 asynchronously. With both bits at 0, startIn low and the other inputs at 0, the outputs are redA=0, yelA=0, grnA=1, redB=1, yelB=0, grnB=0, timerKick=0.
- R2: While startIn is 1, all seven outputs are 0. After a rising edge with startIn at 1, both state bits are 0.
- R3: The next value of stateLo is (not startIn) and (not redB). redA always equals this next value.
- R4: The next value of stateHi is (not startIn) and (not grnA) and (not grnB).
- R5: With hold = (not stateHi) or (not delayDone), redB = (not startIn) and (stateLo xor hold).
- R6: With split = (senseSide and not stateHi) or (not stateLo and stateHi), yelA = redB and split, and grnA = redB and not split.
- R7: yelB = (not startIn) and stateLo and ((senseMain and not stateHi) or (not delayDone and stateHi)).
- R8: grnB = (not startIn) and (not redB) and (not yelB).
- R9: timerKick = ((not stateLo) and (not stateHi) and senseSide and (not startIn)) or ((not startIn) and stateLo and (not stateHi) and senseMain).
- R10: A change on any input changes the outputs within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state bits sample on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of both state bits |
| startIn | input | 1 | Synchronous start; clears state, gates every output |
| senseMain | input | 1 | Road A traffic / timer flag |
| senseSide | input | 1 | Road B traffic / timer flag |
| delayDone | input | 1 | Interval timer elapsed flag |
| redA | output | 1 | Red lamp, road A |
| yelA | output | 1 | Yellow lamp, road A |
| grnA | output | 1 | Green lamp, road A |
| redB | output | 1 | Red lamp, road B |
| yelB | output | 1 | Yellow lamp, road B |
| grnB | output | 1 | Green lamp, road B |
| timerKick | output | 1 | Strobe that restarts the external interval timer |

## Verification
Long random input runs with a rare start pulse walk the state through all four encodings under every sensor combination, and a bench model of the equations tells apart an error in any single term since each term flips at least one lamp in some reachable state. Directed sequences hold the block at its initial state while toggling the side sensor, which separates the yellow and green split for road A and shows the same-cycle response; a forced move into the stateHi state checks the next-state path for that bit through the lamp pattern it produces. Start pulses inserted from every state confirm both the output gating and the clearing of the state.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int StateW = 2;

  typedef struct packed {
    logic runEn;   // not startIn
    logic bitLo;   // current low state bit
    logic bitHi;   // current high state bit
  } ctrlStrobe_t;
endpackage

// File: rtl/tlc_ctrl.sv
module tlc_ctrl
  import tlc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        nextLo,
  input  logic        nextHi,
  output ctrlStrobe_t strobe
);
  logic [StateW-1:0] stateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= '0;
    else       stateQ <= {nextHi, nextLo};
  end

  always_comb begin
    strobe.runEn = ~startIn;
    strobe.bitLo = stateQ[0];
    strobe.bitHi = stateQ[1];
  end

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> (stateQ == '0));
endmodule

// File: rtl/tlc_datapath.sv
module tlc_datapath
  import tlc_pkg::*;
(
  input  ctrlStrobe_t strobe,
  input  logic        senseMain,
  input  logic        senseSide,
  input  logic        delayDone,
  output logic        nextLo,
  output logic        nextHi,
  output logic        redA,
  output logic        yelA,
  output logic        grnA,
  output logic        redB,
  output logic        yelB,
  output logic        grnB,
  output logic        timerKick
);
  logic holdTerm, splitTerm, busyB, kickSide, waitB, idleSide, kickIdle;

  always_comb begin
    holdTerm  = ~strobe.bitHi | ~delayDone;
    redB      = strobe.runEn & (strobe.bitLo ^ holdTerm);
    nextLo    = strobe.runEn & ~redB;
    redA      = nextLo;

    splitTerm = (senseSide & ~strobe.bitHi) | (~strobe.bitLo & strobe.bitHi);
    yelA      = redB & splitTerm;
    grnA      = redB & ~splitTerm;

    busyB     = strobe.runEn & strobe.bitLo;
    kickSide  = senseMain & ~strobe.bitHi & busyB;
    waitB     = ~delayDone & strobe.bitHi;
    yelB      = (waitB & busyB) | kickSide;
    grnB      = strobe.runEn & ~redB & ~yelB;

    nextHi    = strobe.runEn & ~grnA & ~grnB;

    idleSide  = ~strobe.bitLo & senseSide & strobe.runEn;
    kickIdle  = ~strobe.bitHi & idleSide;
    timerKick = kickIdle | kickSide;
  end
endmodule

// File: rtl/tlc_top.sv
module tlc_top
  import tlc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startIn,
  input  logic senseMain,
  input  logic senseSide,
  input  logic delayDone,
  output logic redA,
  output logic yelA,
  output logic grnA,
  output logic redB,
  output logic yelB,
  output logic grnB,
  output logic timerKick
);
  ctrlStrobe_t strobe;
  logic nextLo, nextHi;

  tlc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .startIn(startIn),
    .nextLo (nextLo),
    .nextHi (nextHi),
    .strobe (strobe)
  );

  tlc_datapath u_dp (
    .strobe   (strobe),
    .senseMain(senseMain),
    .senseSide(senseSide),
    .delayDone(delayDone),
    .nextLo   (nextLo),
    .nextHi   (nextHi),
    .redA     (redA),
    .yelA     (yelA),
    .grnA     (grnA),
    .redB     (redB),
    .yelB     (yelB),
    .grnB     (grnB),
    .timerKick(timerKick)
  );

  // R2
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    startIn |-> ({redA, yelA, grnA, redB, yelB, grnB, timerKick} == 7'b0));

  // R3
  red_a_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    redA |=> strobe.bitLo);

  // R3
  red_a_lo_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !redA |=> !strobe.bitLo);

  // R4
  green_hi_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grnA || grnB) |=> !strobe.bitHi);

  // R6
  road_a_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    (yelA || grnA) |-> (redB && $onehot0({yelA, grnA})));

  // R8
  road_b_green_chk: assert property (@(posedge clk) disable iff (!rstN)
    grnB |-> (!redB && !yelB));
endmodule

// File: tb/tlc_top_bench.sv
module tlc_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0, senseMain = 1'b0, senseSide = 1'b0, delayDone = 1'b0;
  logic redA, yelA, grnA, redB, yelB, grnB, timerKick;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;
  logic mLo = 1'b0, mHi = 1'b0;

  always #2.5 clk = ~clk;

  tlc_top u_tlc_top (
    .clk(clk), .rstN(rstN), .startIn(startIn), .senseMain(senseMain),
    .senseSide(senseSide), .delayDone(delayDone), .redA(redA), .yelA(yelA),
    .grnA(grnA), .redB(redB), .yelB(yelB), .grnB(grnB), .timerKick(timerKick)
  );

  // {nextLo, nextHi, redA, yelA, grnA, redB, yelB, grnB, timerKick}
  function automatic logic [8:0] refModel(input logic lo, input logic hi,
      input logic st, input logic s1, input logic s2, input logic d1);
    logic rb, ya, ga, yb, gb, nl, nh, kk, sp;
    rb = !st && (lo ^ (!hi || !d1));
    sp = (s2 && !hi) || (!lo && hi);
    ya = rb && sp;
    ga = rb && !sp;
    yb = !st && lo && ((s1 && !hi) || (!d1 && hi));
    gb = !st && !rb && !yb;
    nl = !st && !rb;
    nh = !st && !ga && !gb;
    kk = (!lo && !hi && s2 && !st) || (!st && lo && !hi && s1);
    return {nl, nh, nl, ya, ga, rb, yb, gb, kk};
  endfunction

  task automatic check1(input string req, input logic act, input logic exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    logic [8:0] e;
    e = refModel(mLo, mHi, startIn, senseMain, senseSide, delayDone);
    check1({tag, " R3 redA"}, redA, e[6]);
    check1({tag, " R6 yelA"}, yelA, e[5]);
    check1({tag, " R6 grnA"}, grnA, e[4]);
    check1({tag, " R5 redB"}, redB, e[3]);
    check1({tag, " R7 yelB"}, yelB, e[2]);
    check1({tag, " R8 grnB"}, grnB, e[1]);
    check1({tag, " R9 timerKick"}, timerKick, e[0]);
  endtask

  // drive at negedge, check before the next rising edge, then advance the model
  task automatic step(input string tag, input logic st, input logic s1,
                      input logic s2, input logic d1);
    logic [8:0] e;
    @(negedge clk);
    startIn = st; senseMain = s1; senseSide = s2; delayDone = d1;
    #1;
    checkAll(tag);
    e = refModel(mLo, mHi, st, s1, s2, d1);
    mLo = e[8];
    mHi = e[7];
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    failCount++;
    testCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state seen through outputs
    #1;
    check1("R1 redA", redA, 1'b0);
    check1("R1 grnA", grnA, 1'b1);
    check1("R1 redB", redB, 1'b1);
    check1("R1 grnB", grnB, 1'b0);
    check1("R1 timerKick", timerKick, 1'b0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R10: same-cycle response at state 00 when senseSide toggles
    @(negedge clk);
    senseSide = 1'b0; #0.5;
    check1("R10 grnA side=0", grnA, 1'b1);
    senseSide = 1'b1; #0.5;
    check1("R10 yelA side=1", yelA, 1'b1);
    check1("R10 timerKick side=1", timerKick, 1'b1);
    senseSide = 1'b0; #0.5;
    check1("R10 grnA side back", grnA, 1'b1);

    // R4: from 00 with senseSide high, stateHi must become 1 (yelA shows it)
    mLo = 1'b0; mHi = 1'b0;
    step("R4 pre", 1'b0, 1'b0, 1'b1, 1'b0);
    step("R4 post", 1'b0, 1'b0, 1'b0, 1'b0);
    check1("R4 yelA after hi set", yelA, 1'b1);
    check1("R4 grnA after hi set", grnA, 1'b0);
    step("walk", 1'b0, 1'b0, 1'b0, 1'b1);
    step("walk", 1'b0, 1'b1, 1'b0, 1'b1);

    // R2: start pulse silences outputs and clears state
    step("R2 start", 1'b1, 1'b1, 1'b1, 1'b1);
    check1("R2 quiet redA", redA, 1'b0);
    check1("R2 quiet redB", redB, 1'b0);
    check1("R2 quiet kick", timerKick, 1'b0);
    step("R2 after", 1'b0, 1'b0, 1'b0, 1'b0);
    check1("R2 cleared grnA", grnA, 1'b1);

    // random sequences, start pulses rare
    for (int i = 0; i < 3000; i++) begin
      logic st;
      st = (($urandom() % 12) == 0);
      step("rand", st, 1'($urandom()), 1'($urandom()), 1'($urandom()));
    end

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    startIn = 1'b0; senseMain = 1'b0; senseSide = 1'b0; delayDone = 1'b0;
    mLo = 1'b0; mHi = 1'b0;
    #1;
    checkAll("R1 async");
    @(negedge clk);
    rstN = 1'b1;
    finish();
  end
endmodule